// File: doc/BRIEF.md
# Set-Associative Translation Cache with Directory-Entry Caching

This block is a translation lookaside buffer for a 32-bit address space with 4 KB pages. It holds two kinds of cached entry side by side. A leaf entry is a page-table entry: it maps one virtual page number straight to a physical page. A directory entry is a page-directory entry: it covers a whole 4 MB region and lets a page-table walker skip the directory read when the leaf entry is missing. Every stored entry carries a kind flag, a tag, a valid bit and the full 32-bit table word.

A lookup presents a 20-bit virtual page number and a 12-bit page offset. One cycle later the block reports whether a leaf entry, a directory entry or nothing matched. It returns the cached word, and on a leaf hit it also returns the physical address. A page-table walker installs new entries through a fill port. A flush input clears every entry whose global bit is zero, so global entries survive a context switch.

The storage is 16 sets of 4 ways. A leaf entry uses the low 4 bits of the page number as its set index and the upper 16 bits as its tag. A directory entry is keyed by the top 10 bits of the page number. The low 4 of those 10 bits select the set, and the remaining 6 bits, zero-extended, form the tag.

Top module: `xlat_cache`

## Requirements
- R1: After reset no lookup hits. A miss returns `rsp_hit`, `rsp_leaf_hit` and `rsp_dir_hit` low, and `rsp_entry` and `rsp_paddr` zero.
- R2: After a leaf fill for page number V, a lookup of V one cycle later reports `rsp_leaf_hit`=1 and `rsp_hit`=1, and returns the filled word on `rsp_entry`.
- R3: On a leaf hit, `rsp_paddr` equals bits 31:12 of the cached word followed by the 12-bit lookup offset. On any other response it is zero.
- R4: When no leaf entry matches but a directory entry for the same top 10 page-number bits is present, the response has `rsp_dir_hit`=1 and `rsp_leaf_hit`=0, and `rsp_entry` carries the directory word.
- R5: When a leaf entry and a directory entry both match, the leaf entry wins. The two hit flags are never high together.
- R6: A fill goes to the lowest-numbered invalid way of its set. If all four ways are valid, it goes to the way named by that set's 2-bit round-robin pointer. That pointer starts at 0 and advances by one only after it has been used.
- R7: A fill whose kind and tag already match a valid way of the set overwrites that way. It takes no other way and leaves the pointer unchanged.
- R8: A flush, done in one cycle, invalidates every entry whose bit 8 (global) is 0 and keeps every entry with bit 8 set.
- R9: A lookup in the same cycle as a fill to the same key sees the contents from before the fill.
- R10: A fill presented in the same cycle as a flush is dropped.
- R11: `rsp_valid` is high exactly one cycle after each cycle with `lk_valid` high. Without a lookup, all hit flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_offset | input | 12 | Page offset used to form the physical address |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 20 | Page number the entry belongs to |
| fill_is_dir | input | 1 | 1 = directory entry, 0 = leaf entry |
| fill_entry | input | 32 | Table word to cache |
| flush | input | 1 | Context-switch invalidate of non-global entries |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | Either kind of entry matched |
| rsp_leaf_hit | output | 1 | A leaf entry matched |
| rsp_dir_hit | output | 1 | Only a directory entry matched |
| rsp_entry | output | 32 | Cached table word, zero on a miss |
| rsp_paddr | output | 32 | Physical address on a leaf hit, else zero |

## Verification
The assertions check several properties on every cycle:
- no set holds two valid ways with the same kind and tag;
- the two hit flags never rise together;
- a fill always leaves its chosen way valid;
- no non-global entry survives a flush;
- a free way is never passed over in favour of the pointer;
- the response valid strobe follows the lookup by one cycle.

Only the bench scenarios can show which way actually gets evicted as the round-robin pointer moves. They also show that a refill keeps the way count unchanged, that a lookup beside a fill returns the old contents, and that a fill during a flush disappears.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XLAT_GLOBAL_BIT = 8;
  localparam int unsigned XLAT_ADDR_W     = 32;
  localparam int unsigned XLAT_OFF_W      = 12;
endpackage

// File: rtl/xlat_probe.sv
module xlat_probe #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             row_vld,
  input  logic [WAYS-1:0]             row_dir,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic                        key_dir,
  input  logic [TAG_W-1:0]            key_tag,
  output logic [WAYS-1:0]             match,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = row_vld[w] && (row_dir[w] == key_dir) && (row_tag[w] == key_tag);
      if (match[w]) hit_way = WAY_W'(w);
    end
    hit = |match;
  end

  // R7: refills reuse the matching way, so a key never sits in two ways
  assert_unique_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_en,
  input  logic [WAYS-1:0]  row_vld,
  input  logic             key_hit,
  input  logic [WAY_W-1:0] key_way,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             use_rr
);
  logic             free_any;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_vld[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    use_rr = 1'b0;
    if (key_hit)       way = key_way;
    else if (free_any) way = free_way;
    else begin
      way    = rr_ptr;
      use_rr = 1'b1;
    end
  end

  // R6: a new key never overwrites a valid way while a free one exists
  assert_free_way_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (check_en && !key_hit && !(&row_vld)) |-> !row_vld[way]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned DIR_W = 10,
  localparam int unsigned ADDR_W = XLAT_ADDR_W,
  localparam int unsigned OFF_W  = XLAT_OFF_W,
  localparam int unsigned VPN_W  = ADDR_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = VPN_W - IDX_W,
  localparam int unsigned DTAG_W = DIR_W - IDX_W,
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [OFF_W-1:0]  lk_offset,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic              fill_is_dir,
  input  logic [ADDR_W-1:0] fill_entry,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_leaf_hit,
  output logic              rsp_dir_hit,
  output logic [ADDR_W-1:0] rsp_entry,
  output logic [ADDR_W-1:0] rsp_paddr
);
  // storage
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0]             vld_d [SETS];
  logic [WAYS-1:0]             dir_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [ADDR_W-1:0]           data_q [SETS][WAYS];
  logic [WAY_W-1:0]            rr_q [SETS];
  logic [WAY_W-1:0]            rr_d [SETS];

  // key formation
  logic [IDX_W-1:0] leaf_set, dir_set, fill_set;
  logic [TAG_W-1:0] leaf_tag, dir_tag, fill_tag;
  logic [DIR_W-1:0] lk_dir, fill_dir;

  always_comb begin
    lk_dir   = lk_vpn[VPN_W-1 -: DIR_W];
    fill_dir = fill_vpn[VPN_W-1 -: DIR_W];
    leaf_set = lk_vpn[IDX_W-1:0];
    leaf_tag = lk_vpn[VPN_W-1:IDX_W];
    dir_set  = lk_dir[IDX_W-1:0];
    dir_tag  = {{(TAG_W-DTAG_W){1'b0}}, lk_dir[DIR_W-1:IDX_W]};
    if (fill_is_dir) begin
      fill_set = fill_dir[IDX_W-1:0];
      fill_tag = {{(TAG_W-DTAG_W){1'b0}}, fill_dir[DIR_W-1:IDX_W]};
    end else begin
      fill_set = fill_vpn[IDX_W-1:0];
      fill_tag = fill_vpn[VPN_W-1:IDX_W];
    end
  end

  // probes: leaf, directory, and fill-side duplicate detection
  logic [WAYS-1:0]  leaf_match, dir_match, fill_match;
  logic             leaf_hit, dir_hit, fill_key_hit;
  logic [WAY_W-1:0] leaf_way, dir_way, fill_key_way;

  xlat_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_leaf_probe (
    .clk(clk), .rst_n(rst_n),
    .row_vld(vld_q[leaf_set]), .row_dir(dir_q[leaf_set]), .row_tag(tag_q[leaf_set]),
    .key_dir(1'b0), .key_tag(leaf_tag),
    .match(leaf_match), .hit(leaf_hit), .hit_way(leaf_way));

  xlat_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_dir_probe (
    .clk(clk), .rst_n(rst_n),
    .row_vld(vld_q[dir_set]), .row_dir(dir_q[dir_set]), .row_tag(tag_q[dir_set]),
    .key_dir(1'b1), .key_tag(dir_tag),
    .match(dir_match), .hit(dir_hit), .hit_way(dir_way));

  xlat_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_probe (
    .clk(clk), .rst_n(rst_n),
    .row_vld(vld_q[fill_set]), .row_dir(dir_q[fill_set]), .row_tag(tag_q[fill_set]),
    .key_dir(fill_is_dir), .key_tag(fill_tag),
    .match(fill_match), .hit(fill_key_hit), .hit_way(fill_key_way));

  // replacement choice
  logic             fill_go;
  logic [WAY_W-1:0] fill_way;
  logic             fill_use_rr;

  assign fill_go = fill_valid && !flush;

  xlat_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .check_en(fill_go),
    .row_vld(vld_q[fill_set]), .key_hit(fill_key_hit), .key_way(fill_key_way),
    .rr_ptr(rr_q[fill_set]), .way(fill_way), .use_rr(fill_use_rr));

  // next state: valid bits and round-robin pointers
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
      rr_d[s]  = rr_q[s];
    end
    if (flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_d[s][w] = vld_q[s][w] && data_q[s][w][XLAT_GLOBAL_BIT];
    end else if (fill_go) begin
      vld_d[fill_set][fill_way] = 1'b1;
      if (fill_use_rr) rr_d[fill_set] = rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= vld_d[s];
        rr_q[s]  <= rr_d[s];
      end
    end
  end

  // payload storage: enabled writes, no reset
  always_ff @(posedge clk) begin
    if (fill_go) begin
      dir_q[fill_set][fill_way]  <= fill_is_dir;
      tag_q[fill_set][fill_way]  <= fill_tag;
      data_q[fill_set][fill_way] <= fill_entry;
    end
  end

  // response next state
  logic              leaf_d, dirh_d;
  logic [ADDR_W-1:0] entry_d, paddr_d;

  always_comb begin
    leaf_d  = lk_valid && leaf_hit;
    dirh_d  = lk_valid && !leaf_hit && dir_hit;
    entry_d = '0;
    paddr_d = '0;
    if (leaf_d) begin
      entry_d = data_q[leaf_set][leaf_way];
      paddr_d = {entry_d[ADDR_W-1:OFF_W], lk_offset};
    end else if (dirh_d) begin
      entry_d = data_q[dir_set][dir_way];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_leaf_hit <= 1'b0;
      rsp_dir_hit  <= 1'b0;
      rsp_entry    <= '0;
      rsp_paddr    <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= leaf_d || dirh_d;
      rsp_leaf_hit <= leaf_d;
      rsp_dir_hit  <= dirh_d;
      rsp_entry    <= entry_d;
      rsp_paddr    <= paddr_d;
    end
  end

  // checks
  logic nonglobal_any;
  always_comb begin
    nonglobal_any = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (vld_q[s][w] && !data_q[s][w][XLAT_GLOBAL_BIT]) nonglobal_any = 1'b1;
  end

  assert_flush_spares_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !nonglobal_any);

  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> vld_q[$past(fill_set)][$past(fill_way)]);

  assert_one_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_leaf_hit, rsp_dir_hit}));

  assert_rsp_follows_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_rsp_without_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit));

  assert_paddr_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && leaf_hit) |=> (rsp_paddr[OFF_W-1:0] == $past(lk_offset)));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, fill_is_dir, flush;
  logic [19:0] lk_vpn, fill_vpn;
  logic [11:0] lk_offset;
  logic [31:0] fill_entry;
  logic        rsp_valid, rsp_hit, rsp_leaf_hit, rsp_dir_hit;
  logic [31:0] rsp_entry, rsp_paddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_offset(lk_offset),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_is_dir(fill_is_dir),
    .fill_entry(fill_entry), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_leaf_hit(rsp_leaf_hit),
    .rsp_dir_hit(rsp_dir_hit), .rsp_entry(rsp_entry), .rsp_paddr(rsp_paddr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    lk_vpn = '0; lk_offset = '0; fill_vpn = '0; fill_is_dir = 1'b0; fill_entry = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic is_dir, input logic [31:0] e);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_is_dir = is_dir; fill_entry = e;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn; lk_offset = off;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // {valid, hit, leaf, dir, entry, paddr} packed for one comparison
  task automatic expect_rsp(input string req, input logic l, input logic d,
                            input logic [31:0] e, input logic [31:0] pa);
    chk(req, {60'd0, rsp_valid, rsp_hit, rsp_leaf_hit, rsp_dir_hit},
             {60'd0, 1'b1, l | d, l, d});
    chk(req, {rsp_entry, rsp_paddr}, {e, pa});
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R11 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
    lookup(20'h12345, 12'h010);
    expect_rsp("R1 miss after reset", 1'b0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R11 no lookup no valid", {62'd0, rsp_valid, rsp_hit}, 64'd0);
  endtask

  task automatic t_leaf_r2();
    do_reset();
    fill(20'hABCDE, 1'b0, 32'hCAFE_1003);
    lookup(20'hABCDE, 12'h5A4);
    expect_rsp("R2 R3 leaf hit", 1'b1, 1'b0, 32'hCAFE_1003, 32'hCAFE_15A4);
    lookup(20'hABCDF, 12'h5A4);
    expect_rsp("R2 other vpn misses", 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic t_dir_r4();
    do_reset();
    fill(20'h12345, 1'b1, 32'h0077_7001);
    lookup(20'h12399, 12'h0FF);
    expect_rsp("R4 dir hit", 1'b0, 1'b1, 32'h0077_7001, 32'h0);
    lookup(20'h12799, 12'h0FF);
    expect_rsp("R4 other region misses", 1'b0, 1'b0, 32'h0, 32'h0);
    fill(20'h12399, 1'b0, 32'h4444_4001);
    lookup(20'h12399, 12'h123);
    expect_rsp("R5 leaf wins over dir", 1'b1, 1'b0, 32'h4444_4001, 32'h4444_4123);
  endtask

  task automatic t_replace_r6();
    do_reset();
    for (int i = 1; i <= 4; i++) fill(20'h00005 + 20'(i << 4), 1'b0, 32'(i) << 12);
    for (int i = 1; i <= 4; i++) begin
      lookup(20'h00005 + 20'(i << 4), 12'h0);
      expect_rsp("R6 four ways held", 1'b1, 1'b0, 32'(i) << 12, 32'(i) << 12);
    end
    fill(20'h00055, 1'b0, 32'h0005_0000);
    lookup(20'h00015, 12'h0);
    expect_rsp("R6 way0 evicted first", 1'b0, 1'b0, 32'h0, 32'h0);
    lookup(20'h00055, 12'h0);
    expect_rsp("R6 new entry present", 1'b1, 1'b0, 32'h0005_0000, 32'h0005_0000);
    fill(20'h00065, 1'b0, 32'h0006_0000);
    lookup(20'h00025, 12'h0);
    expect_rsp("R6 pointer advanced to way1", 1'b0, 1'b0, 32'h0, 32'h0);
    lookup(20'h00035, 12'h0);
    expect_rsp("R6 way2 kept", 1'b1, 1'b0, 32'h3000, 32'h3000);
  endtask

  task automatic t_refill_r7();
    do_reset();
    fill(20'h00107, 1'b0, 32'h1111_1000);
    fill(20'h00107, 1'b0, 32'h2222_2000);
    fill(20'h00207, 1'b0, 32'h0000_3000);
    fill(20'h00307, 1'b0, 32'h0000_4000);
    fill(20'h00407, 1'b0, 32'h0000_5000);
    lookup(20'h00107, 12'h0);
    expect_rsp("R7 refill overwrote", 1'b1, 1'b0, 32'h2222_2000, 32'h2222_2000);
    fill(20'h00507, 1'b0, 32'h0000_6000);
    lookup(20'h00107, 12'h0);
    expect_rsp("R7 refill used one way", 1'b0, 1'b0, 32'h0, 32'h0);
    lookup(20'h00407, 12'h0);
    expect_rsp("R7 last way kept", 1'b1, 1'b0, 32'h5000, 32'h5000);
  endtask

  task automatic t_flush_r8();
    do_reset();
    fill(20'h0A001, 1'b0, 32'h9000_0100);
    fill(20'h0A002, 1'b0, 32'h9100_0000);
    fill(20'h0B000, 1'b1, 32'h8000_0101);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lookup(20'h0A001, 12'h004);
    expect_rsp("R8 global leaf kept", 1'b1, 1'b0, 32'h9000_0100, 32'h9000_0004);
    lookup(20'h0A002, 12'h004);
    expect_rsp("R8 non-global leaf dropped", 1'b0, 1'b0, 32'h0, 32'h0);
    lookup(20'h0B3FF, 12'h004);
    expect_rsp("R8 global dir kept", 1'b0, 1'b1, 32'h8000_0101, 32'h0);
  endtask

  task automatic t_same_cycle_r9();
    do_reset();
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h3C3C9; fill_is_dir = 1'b0; fill_entry = 32'h5555_5000;
    lk_valid = 1'b1; lk_vpn = 20'h3C3C9; lk_offset = 12'h001;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    expect_rsp("R9 lookup sees pre-fill", 1'b0, 1'b0, 32'h0, 32'h0);
    lookup(20'h3C3C9, 12'h001);
    expect_rsp("R9 later lookup sees fill", 1'b1, 1'b0, 32'h5555_5000, 32'h5555_5001);
  endtask

  task automatic t_flush_fill_r10();
    do_reset();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h77770; fill_is_dir = 1'b0; fill_entry = 32'h6666_6100;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup(20'h77770, 12'h0);
    expect_rsp("R10 fill during flush dropped", 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    t_reset_r1();
    t_leaf_r2();
    t_dir_r4();
    t_replace_r6();
    t_refill_r7();
    t_flush_r8();
    t_same_cycle_r9();
    t_flush_fill_r10();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule